// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block holds the loads, stores and memory barriers that an out-of-order core has dispatched but not yet retired. For each one it decides when the operation may issue to memory. An operation becomes issuable once two conditions hold. Its source registers must be ready. It must also have no outstanding producer: a predicted older store, or an active barrier that orders it. Issuable operations are reported one per cycle, oldest sequence number first, on a registered ready output.

Each entry is created through a single insert port. That port carries the sequence number, the thread, the kind of operation, the register-ready state, a non-speculative flag, and a producing-store sequence number predicted outside the block. Sequence number zero means "no producer".

Side ports handle the rest of an entry's life:
- register wakeup;
- completion of a store or barrier, which wakes the entries waiting on it;
- retirement, which frees the entry;
- reschedule and replay of operations that were already sent;
- explicit release of non-speculative operations;
- per-thread squash of younger entries.

Top module: `mem_dep_tracker`

## Requirements
- R1: After reset the table is empty, `ins_full` is 0, `rdy_valid` is 0 and no barrier is active.
- R2: The kind field encodes 2'b00 load, 2'b01 store, 2'b10 full memory barrier and 2'b11 store-only barrier. A load or store inserted with its register-ready flag set, and whose producer is zero or matches no held entry, appears on `rdy_seq` with `rdy_valid` high on the second clock edge after the insert.
- R3: An entry is sent only when it is both register-ready and memory-ready. Whichever of the two becomes true second triggers the send, one time.
- R4: Completion on `wake_*` wakes dependents only if the completing entry is a store or a barrier. A completion naming a load changes nothing. A woken dependent that is not yet register-ready is only marked memory-ready.
- R5: A full barrier becomes the producer of every later load and store. A store-only barrier becomes the producer of later stores only; later loads fall back to the predicted producer.
- R6: Completing a barrier clears the load-side and store-side barrier states only where the recorded sequence number equals the completing one. A newer barrier keeps blocking.
- R7: An entry inserted as non-speculative is never sent by register or memory wakeup. It is sent only when `release_seq` names it.
- R8: A replay request re-sends every entry marked by a reschedule, oldest sequence number first, one per cycle.
- R9: A squash removes every entry of the named thread whose sequence number is greater than `squash_seq`, and drops those entries from the reschedule set. Entries of other threads are untouched.
- R10: Retiring an entry frees its slot. With all slots held, `ins_full` is 1 and an insert is ignored.
- R11: At most one entry is sent per cycle. When several are issuable, the one with the smallest sequence number goes first.
- R12: An insert whose producer completes in the same cycle is memory-ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted operation (nonzero) |
| ins_tid | input | TID_W | Thread of the inserted operation |
| ins_kind | input | 2 | 00 load, 01 store, 10 full barrier, 11 store-only barrier |
| ins_regs_rdy | input | 1 | Source registers already ready |
| ins_nonspec | input | 1 | Operation must wait for explicit release |
| ins_pred_seq | input | SEQ_W | Predicted producing store, 0 for none |
| ins_full | output | 1 | No free slot; insert ignored |
| regs_valid | input | 1 | Register wakeup request |
| regs_seq | input | SEQ_W | Entry whose registers became ready |
| wake_valid | input | 1 | Completion of a store or barrier |
| wake_seq | input | SEQ_W | Sequence number that completed |
| done_valid | input | 1 | Retire request |
| done_seq | input | SEQ_W | Entry to free |
| resched_valid | input | 1 | Reschedule request |
| resched_seq | input | SEQ_W | Entry to hold for replay |
| replay_valid | input | 1 | Re-send all rescheduled entries |
| release_valid | input | 1 | Non-speculative release request |
| release_seq | input | SEQ_W | Non-speculative entry to send |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Thread being squashed |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| rdy_valid | output | 1 | `rdy_seq` holds an issuable operation |
| rdy_seq | output | SEQ_W | Sequence number allowed to issue |

## Verification
Two cases make separate ports meet in one cycle. In the first, an insert names a producer that is completing in that same cycle. The bench drives `ins_valid` and `wake_valid` together, with `ins_pred_seq` equal to `wake_seq`. The new load must appear on the ready output two edges later instead of waiting forever. In the second, a barrier completion wakes two waiting loads at once. The bench judges the arbitration by reading the two sequence numbers on consecutive cycles in ascending order.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  typedef enum logic [1:0] {
    K_LOAD  = 2'b00,
    K_STORE = 2'b01,
    K_MBAR  = 2'b10,
    K_WBAR  = 2'b11
  } kind_e;

  function automatic logic is_memop(kind_e k);
    return (k == K_LOAD) || (k == K_STORE);
  endfunction

  function automatic logic is_barrier(kind_e k);
    return (k == K_MBAR) || (k == K_WBAR);
  endfunction
endpackage

// File: rtl/mdt_free_find.sv
module mdt_free_find #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest-index free slot
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mdt_oldest_pick.sv
module mdt_oldest_pick #(
  parameter int N     = 16,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  input  logic [SEQ_W-1:0] seq [N],
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [SEQ_W-1:0] best;

  // smallest sequence number among requesters
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || seq[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = seq[i];
      end
    end
  end
endmodule

// File: rtl/mem_dep_tracker.sv
module mem_dep_tracker
  import mdt_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [TID_W-1:0] ins_tid,
  input  logic [1:0]       ins_kind,
  input  logic             ins_regs_rdy,
  input  logic             ins_nonspec,
  input  logic [SEQ_W-1:0] ins_pred_seq,
  output logic             ins_full,
  input  logic             regs_valid,
  input  logic [SEQ_W-1:0] regs_seq,
  input  logic             wake_valid,
  input  logic [SEQ_W-1:0] wake_seq,
  input  logic             done_valid,
  input  logic [SEQ_W-1:0] done_seq,
  input  logic             resched_valid,
  input  logic [SEQ_W-1:0] resched_seq,
  input  logic             replay_valid,
  input  logic             release_valid,
  input  logic [SEQ_W-1:0] release_seq,
  input  logic             squash_valid,
  input  logic [TID_W-1:0] squash_tid,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic             rdy_valid,
  output logic [SEQ_W-1:0] rdy_seq
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry state
  logic [ENTRIES-1:0] e_vld, e_regs, e_mem, e_pend, e_rsch, e_nspec;
  logic [ENTRIES-1:0] e_vld_n, e_regs_n, e_mem_n, e_pend_n, e_rsch_n, e_nspec_n;
  logic [SEQ_W-1:0]   e_seq  [ENTRIES];
  logic [SEQ_W-1:0]   e_seq_n[ENTRIES];
  logic [SEQ_W-1:0]   e_prod [ENTRIES];
  logic [SEQ_W-1:0]   e_prod_n[ENTRIES];
  logic [TID_W-1:0]   e_tid  [ENTRIES];
  logic [TID_W-1:0]   e_tid_n[ENTRIES];
  kind_e              e_kind [ENTRIES];
  kind_e              e_kind_n[ENTRIES];

  // barrier tracking
  logic             ld_bar, st_bar, ld_bar_n, st_bar_n;
  logic [SEQ_W-1:0] ld_bar_seq, st_bar_seq, ld_bar_seq_n, st_bar_seq_n;

  kind_e              ins_k;
  logic [SEQ_W-1:0]   prod_seq;
  logic [ENTRIES-1:0] hit_prod, kill, pick_req;
  logic               wake_ok, wake_bar, ins_mem_ok, ins_live;
  logic               free_vld, pick_vld;
  logic [IDX_W-1:0]   free_idx, pick_idx;

  assign ins_k = kind_e'(ins_kind);

  // producer selection: active barrier first, prediction otherwise
  always_comb begin
    if (ins_k == K_LOAD && ld_bar)       prod_seq = ld_bar_seq;
    else if (ins_k == K_STORE && st_bar) prod_seq = st_bar_seq;
    else                                 prod_seq = ins_pred_seq;
  end

  // associative lookups over the table
  always_comb begin
    wake_ok  = 1'b0;
    wake_bar = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_prod[i] = e_vld[i] && (e_seq[i] == prod_seq);
      kill[i] = e_vld[i] &&
                ((done_valid && e_seq[i] == done_seq) ||
                 (squash_valid && e_tid[i] == squash_tid && e_seq[i] > squash_seq));
      if (wake_valid && e_vld[i] && e_seq[i] == wake_seq && e_kind[i] != K_LOAD)
        wake_ok = 1'b1;
      if (wake_valid && e_vld[i] && e_seq[i] == wake_seq && is_barrier(e_kind[i]))
        wake_bar = 1'b1;
    end
  end

  assign ins_mem_ok = (prod_seq == '0) || !(|hit_prod) || (wake_ok && wake_seq == prod_seq);
  assign ins_live   = !(squash_valid && ins_tid == squash_tid && ins_seq > squash_seq);
  assign pick_req   = e_pend & ~kill;
  assign ins_full   = !free_vld;

  mdt_free_find #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
    .busy (e_vld),
    .found(free_vld),
    .idx  (free_idx)
  );

  mdt_oldest_pick #(.N(ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
    .req  (pick_req),
    .seq  (e_seq),
    .found(pick_vld),
    .idx  (pick_idx)
  );

  // next-state of the table
  always_comb begin
    logic nr, nm;
    e_vld_n      = e_vld;
    e_regs_n     = e_regs;
    e_mem_n      = e_mem;
    e_pend_n     = e_pend;
    e_rsch_n     = e_rsch;
    e_nspec_n    = e_nspec;
    e_seq_n      = e_seq;
    e_prod_n     = e_prod;
    e_tid_n      = e_tid;
    e_kind_n     = e_kind;
    ld_bar_n     = ld_bar;
    st_bar_n     = st_bar;
    ld_bar_seq_n = ld_bar_seq;
    st_bar_seq_n = st_bar_seq;

    if (pick_vld) e_pend_n[pick_idx] = 1'b0;

    for (int i = 0; i < ENTRIES; i++) begin
      nr = e_regs[i] | (regs_valid && e_vld[i] && e_seq[i] == regs_seq);
      nm = e_mem[i]  | (wake_ok && e_vld[i] && e_prod[i] == wake_seq);
      e_regs_n[i] = nr;
      e_mem_n[i]  = nm;
      if (e_vld[i] && !(e_regs[i] && e_mem[i]) && nr && nm &&
          !e_nspec[i] && is_memop(e_kind[i]))
        e_pend_n[i] = 1'b1;
      if (replay_valid && e_vld[i] && e_rsch[i]) begin
        e_pend_n[i] = 1'b1;
        e_rsch_n[i] = 1'b0;
      end
      if (release_valid && e_vld[i] && e_nspec[i] && e_seq[i] == release_seq)
        e_pend_n[i] = 1'b1;
      if (resched_valid && e_vld[i] && e_seq[i] == resched_seq) begin
        e_rsch_n[i] = 1'b1;
        e_pend_n[i] = 1'b0;
      end
      if (kill[i]) begin
        e_vld_n[i]  = 1'b0;
        e_pend_n[i] = 1'b0;
        e_rsch_n[i] = 1'b0;
      end
    end

    if (wake_bar) begin
      if (ld_bar && ld_bar_seq == wake_seq) ld_bar_n = 1'b0;
      if (st_bar && st_bar_seq == wake_seq) st_bar_n = 1'b0;
    end

    if (ins_valid && free_vld && ins_live) begin
      e_vld_n[free_idx]   = 1'b1;
      e_seq_n[free_idx]   = ins_seq;
      e_tid_n[free_idx]   = ins_tid;
      e_kind_n[free_idx]  = ins_k;
      e_prod_n[free_idx]  = prod_seq;
      e_rsch_n[free_idx]  = 1'b0;
      e_nspec_n[free_idx] = 1'b0;
      if (is_barrier(ins_k)) begin
        e_regs_n[free_idx] = 1'b1;
        e_mem_n[free_idx]  = 1'b1;
        e_pend_n[free_idx] = 1'b0;
        st_bar_n           = 1'b1;
        st_bar_seq_n       = ins_seq;
        if (ins_k == K_MBAR) begin
          ld_bar_n     = 1'b1;
          ld_bar_seq_n = ins_seq;
        end
      end else if (ins_nonspec) begin
        e_nspec_n[free_idx] = 1'b1;
        e_regs_n[free_idx]  = ins_regs_rdy;
        e_mem_n[free_idx]   = 1'b1;
        e_pend_n[free_idx]  = 1'b0;
      end else begin
        e_regs_n[free_idx] = ins_regs_rdy;
        e_mem_n[free_idx]  = ins_mem_ok;
        e_pend_n[free_idx] = ins_regs_rdy && ins_mem_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld      <= '0;
      e_regs     <= '0;
      e_mem      <= '0;
      e_pend     <= '0;
      e_rsch     <= '0;
      e_nspec    <= '0;
      ld_bar     <= 1'b0;
      st_bar     <= 1'b0;
      ld_bar_seq <= '0;
      st_bar_seq <= '0;
      rdy_valid  <= 1'b0;
      rdy_seq    <= '0;
    end else begin
      e_vld      <= e_vld_n;
      e_regs     <= e_regs_n;
      e_mem      <= e_mem_n;
      e_pend     <= e_pend_n;
      e_rsch     <= e_rsch_n;
      e_nspec    <= e_nspec_n;
      ld_bar     <= ld_bar_n;
      st_bar     <= st_bar_n;
      ld_bar_seq <= ld_bar_seq_n;
      st_bar_seq <= st_bar_seq_n;
      rdy_valid  <= pick_vld;
      rdy_seq    <= e_seq[pick_idx];
    end
  end

  // payload arrays carry no reset
  always_ff @(posedge clk) begin
    e_seq  <= e_seq_n;
    e_prod <= e_prod_n;
    e_tid  <= e_tid_n;
    e_kind <= e_kind_n;
  end

  // ---------------- assertions ----------------
  a_r11_pick_is_pending: assert property (@(posedge clk) disable iff (rst)
    pick_vld |-> (e_vld[pick_idx] && e_pend[pick_idx]));

  a_r3_pick_needs_both: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && !e_nspec[pick_idx]) |-> (e_regs[pick_idx] && e_mem[pick_idx]));

  a_r10_full_blocks_insert: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_full) |=> ($countones(e_vld) <= $past($countones(e_vld))));

  a_r5_store_barrier_not_older: assert property (@(posedge clk) disable iff (rst)
    (ld_bar && st_bar) |-> (st_bar_seq >= ld_bar_seq));

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_sq_chk
      a_r9_squash_younger_gone: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> !(e_vld[g] && e_tid[g] == $past(squash_tid) &&
                           e_seq[g] > $past(squash_seq)));
    end
  endgenerate
endmodule

// File: tb/mem_dep_tracker_bench.sv
module mem_dep_tracker_bench;
  localparam int CLK_P = 10;
  localparam int SEQ_W = 16;
  localparam int TID_W = 1;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, MB = 2'b10, WB = 2'b11;

  // {kind[19:18], regs[17], expect_out[16], seq[15:8], pred[7:0]}
  localparam logic [19:0] VEC [0:5] = '{
    {LD, 1'b1, 1'b1, 8'd1, 8'd0},
    {ST, 1'b0, 1'b0, 8'd2, 8'd0},
    {LD, 1'b1, 1'b0, 8'd3, 8'd2},
    {LD, 1'b1, 1'b1, 8'd4, 8'd9},
    {ST, 1'b1, 1'b1, 8'd5, 8'd0},
    {LD, 1'b0, 1'b0, 8'd6, 8'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ins_valid = 0, ins_regs_rdy = 0, ins_nonspec = 0;
  logic [SEQ_W-1:0] ins_seq = '0, ins_pred_seq = '0;
  logic [TID_W-1:0] ins_tid = '0;
  logic [1:0] ins_kind = '0;
  logic ins_full;
  logic regs_valid = 0, wake_valid = 0, done_valid = 0, resched_valid = 0;
  logic replay_valid = 0, release_valid = 0, squash_valid = 0;
  logic [SEQ_W-1:0] regs_seq = '0, wake_seq = '0, done_seq = '0, resched_seq = '0;
  logic [SEQ_W-1:0] release_seq = '0, squash_seq = '0;
  logic [TID_W-1:0] squash_tid = '0;
  logic rdy_valid;
  logic [SEQ_W-1:0] rdy_seq;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  mem_dep_tracker u_mem_dep_tracker (
    .clk, .rst, .ins_valid, .ins_seq, .ins_tid, .ins_kind, .ins_regs_rdy,
    .ins_nonspec, .ins_pred_seq, .ins_full, .regs_valid, .regs_seq,
    .wake_valid, .wake_seq, .done_valid, .done_seq, .resched_valid,
    .resched_seq, .replay_valid, .release_valid, .release_seq,
    .squash_valid, .squash_tid, .squash_seq, .rdy_valid, .rdy_seq
  );

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    ins_valid = 0; regs_valid = 0; wake_valid = 0; done_valid = 0;
    resched_valid = 0; replay_valid = 0; release_valid = 0; squash_valid = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic v, input int s);
    chk(req, 32'(rdy_valid), 32'(v));
    if (v) chk(req, 32'(rdy_seq), 32'(s));
  endtask

  task automatic do_reset();
    idle(); rst = 1; cyc(); cyc(); rst = 0;
  endtask

  task automatic ins(input logic [1:0] k, input int s, input int p,
                     input logic r, input logic ns, input logic t);
    ins_valid = 1; ins_kind = k; ins_seq = SEQ_W'(s); ins_pred_seq = SEQ_W'(p);
    ins_regs_rdy = r; ins_nonspec = ns; ins_tid = t;
    cyc(); idle();
  endtask

  task automatic regs(input int s);    regs_valid = 1; regs_seq = SEQ_W'(s); cyc(); idle(); endtask
  task automatic wake(input int s);    wake_valid = 1; wake_seq = SEQ_W'(s); cyc(); idle(); endtask
  task automatic retire(input int s);  done_valid = 1; done_seq = SEQ_W'(s); cyc(); idle(); endtask
  task automatic resched(input int s); resched_valid = 1; resched_seq = SEQ_W'(s); cyc(); idle(); endtask
  task automatic release_op(input int s); release_valid = 1; release_seq = SEQ_W'(s); cyc(); idle(); endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 full", 32'(ins_full), 0);
    chk("R1 rdy", 32'(rdy_valid), 0);

    // R2 table walk
    foreach (VEC[i]) begin
      ins(VEC[i][19:18], int'(VEC[i][15:8]), int'(VEC[i][7:0]), VEC[i][17], 0, 0);
      cyc();
      expect_out("R2 vec", VEC[i][16], int'(VEC[i][15:8]));
    end

    // R3 / R4 wake rules
    do_reset();
    ins(ST, 10, 0, 1, 0, 0); cyc(); expect_out("R2 store", 1, 10);
    ins(LD, 11, 10, 1, 0, 0); cyc(); expect_out("R3 wait", 0, 0);
    ins(LD, 12, 10, 0, 0, 0); cyc(); expect_out("R3 wait2", 0, 0);
    ins(LD, 13, 0, 1, 0, 0); cyc(); expect_out("R2 load", 1, 13);
    wake(13); cyc(); expect_out("R4 load wakes nothing", 0, 0);
    wake(10); cyc(); expect_out("R4 wake dep", 1, 11);
    cyc(); expect_out("R4 mem only", 0, 0);
    regs(12); cyc(); expect_out("R3 second cond", 1, 12);
    cyc(); expect_out("R3 once", 0, 0);

    // R5 / R11 barriers
    do_reset();
    ins(MB, 20, 0, 1, 0, 0);
    ins(LD, 21, 0, 1, 0, 0); cyc(); expect_out("R5 ld blocked", 0, 0);
    ins(WB, 22, 0, 1, 0, 0);
    ins(ST, 23, 0, 1, 0, 0); cyc(); expect_out("R5 st blocked", 0, 0);
    ins(LD, 24, 0, 1, 0, 0); cyc(); expect_out("R5 ld blocked2", 0, 0);
    wake(22); cyc(); expect_out("R5 wbar wake", 1, 23);
    wake(20); cyc(); expect_out("R11 oldest", 1, 21);
    cyc(); expect_out("R11 next", 1, 24);
    ins(LD, 25, 0, 1, 0, 0); cyc(); expect_out("R6 cleared", 1, 25);

    // R6 newer barrier keeps blocking
    do_reset();
    ins(MB, 30, 0, 1, 0, 0);
    ins(MB, 31, 0, 1, 0, 0);
    wake(30);
    ins(LD, 32, 0, 1, 0, 0); cyc(); expect_out("R6 newer blocks", 0, 0);
    wake(31); cyc(); expect_out("R6 release", 1, 32);

    // R5 store-only barrier lets loads pass
    do_reset();
    ins(WB, 40, 0, 1, 0, 0);
    ins(LD, 41, 0, 1, 0, 0); cyc(); expect_out("R5 ld passes wbar", 1, 41);

    // R7 non-speculative
    do_reset();
    ins(LD, 50, 0, 1, 1, 0); cyc(); expect_out("R7 held", 0, 0);
    cyc(); expect_out("R7 held2", 0, 0);
    release_op(50); cyc(); expect_out("R7 release", 1, 50);

    // R8 reschedule / replay
    do_reset();
    for (int k = 60; k < 63; k++) begin
      ins(LD, k, 0, 1, 0, 0); cyc(); expect_out("R2 replay prep", 1, k);
    end
    resched(62); resched(60); cyc(); expect_out("R8 held", 0, 0);
    replay_valid = 1; cyc(); idle();
    cyc(); expect_out("R8 first", 1, 60);
    cyc(); expect_out("R8 second", 1, 62);
    cyc(); expect_out("R8 done", 0, 0);

    // R9 squash
    do_reset();
    ins(LD, 70, 0, 0, 0, 0);
    ins(LD, 71, 0, 0, 0, 1);
    ins(LD, 72, 0, 0, 0, 0);
    ins(LD, 73, 0, 1, 0, 0); cyc(); expect_out("R2 squash prep", 1, 73);
    resched(73);
    squash_valid = 1; squash_tid = 0; squash_seq = 70; cyc(); idle();
    replay_valid = 1; cyc(); idle();
    cyc(); expect_out("R9 replay dropped", 0, 0);
    regs(72); cyc(); expect_out("R9 removed", 0, 0);
    regs(70); cyc(); expect_out("R9 older kept", 1, 70);
    regs(71); cyc(); expect_out("R9 other thread", 1, 71);

    // R10 full / free
    do_reset();
    for (int k = 0; k < 16; k++) ins(LD, 80 + k, 0, 0, 0, 0);
    chk("R10 full", 32'(ins_full), 1);
    ins(LD, 96, 0, 1, 0, 0); cyc(); expect_out("R10 ignored", 0, 0);
    regs(96); cyc(); expect_out("R10 not held", 0, 0);
    retire(80);
    chk("R10 freed", 32'(ins_full), 0);
    ins(LD, 96, 0, 1, 0, 0); cyc(); expect_out("R10 reuse", 1, 96);

    // R12 insert with producer completing in the same cycle
    do_reset();
    ins(ST, 100, 0, 0, 0, 0);
    ins_valid = 1; ins_kind = LD; ins_seq = 101; ins_pred_seq = 100;
    ins_regs_rdy = 1; ins_nonspec = 0; ins_tid = 0;
    wake_valid = 1; wake_seq = 100;
    cyc(); idle();
    cyc(); expect_out("R12 same cycle", 1, 101);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule